// File: doc/BRIEF.md
# S/PDIF Receiver Lock Sequencer

This block sequences how a digital audio receiver gains lock on a biphase-mark serial stream. It does not measure pulse widths or decode symbols. It decides when an external timing estimator may start a lock attempt, counts the attempts that fail, and reports the phase the receiver is in. A 2-bit mode input switches the block between off, lock-only and full reception. In lock-only mode it stops once lock is gained. In full reception mode it goes on to enable the data path.

Before the first attempt the block can wait for signs of life on the line. When the wait flag is set, it counts level changes on the selected input and starts only after four have been seen. The source is one of four serial lines, chosen by a 2-bit select. The selected line passes through a two-stage synchronizer, and a level change is found by comparing two consecutive synchronized samples. A 2-bit budget code sets how many attempts are allowed. When that budget is used up, the block parks in an error state until it is switched off.

Top module: `spdif_lock_ctrl`

## Requirements
- R1: After reset, `lockState` is 0 (idle), and `estStart` and `dataEn` are low. `lockState` only takes the codes 0 idle, 1 waiting for activity, 2 locking, 3 locked-hold, 4 receiving and 5 lock-error.
- R2: When `runMode` is 0 or 2 (2 is reserved), `lockState` is 0 and `dataEn` is low after the next clock edge, whatever the state was. Both the level-change count and the failed-attempt count are cleared, so a later enable starts from zero.
- R3: When `runMode` becomes 1 or 3 with `waitLine` low, the edge that leaves idle enters state 2. In the same cycle `estStart` is high for exactly one cycle.
- R4: When `runMode` becomes 1 or 3 with `waitLine` high, the block enters state 1. It stays there until four level changes have been counted on the selected line. It then enters state 2 with a one-cycle `estStart` pulse, four clock edges after the fourth change is applied.
- R5: `lineSel` picks bit `lineSel` of `serialIn` as the watched line. Level changes on the other three bits have no effect.
- R6: In state 2, a high `estFail` that does not use up the budget keeps the block in state 2 and issues a new one-cycle `estStart` pulse. It also adds one to the failed-attempt count.
- R7: `budgetCode` n allows 4^n attempts in total (1, 4, 16 or 64). The failure that ends the last allowed attempt moves the block to state 5.
- R8: State 5 holds while `runMode` stays 1 or 3. Only `runMode` 0 or 2 leaves it.
- R9: A high `estOk` in state 2 moves the block to state 3 when `runMode` is 1. When `runMode` is 3 it moves to state 4, where `dataEn` is high. `dataEn` is low in every other state.
- R10: While locked, changing `runMode` from 1 to 3 moves state 3 to state 4, and changing it from 3 to 1 moves state 4 to state 3.
- R11: When `estOk` and `estFail` are high in the same cycle in state 2, success wins.
- R12: `estOk` and `estFail` have no effect in any state other than 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runMode | input | 2 | 0/2 off, 1 lock only, 3 full reception |
| budgetCode | input | 2 | Attempt budget code, 4^code attempts |
| waitLine | input | 1 | Wait for four line changes before the first attempt |
| lineSel | input | 2 | Selects which serial input is watched |
| serialIn | input | 4 | Asynchronous serial input lines |
| estOk | input | 1 | Lock attempt succeeded (pulse from estimator) |
| estFail | input | 1 | Lock attempt failed (pulse from estimator) |
| estStart | output | 1 | One-cycle request to start a lock attempt |
| lockState | output | 3 | Current phase code |
| dataEn | output | 1 | Data path enable, high in the receiving state |

## Verification
The bench counts failures for every budget code up to 64 attempts, because an off-by-one in the limit compare would give up one attempt early or late. It toggles the unselected lines first and then stops one change short of the activity threshold. A design that reads the wrong line, or counts changes with the wrong latency, would start locking too soon. It switches the block off part way through a wait and part way through a retry series, and then checks that the next session needs a full new set of changes and a full budget. A design that keeps stale counts would end either phase early. It also drives success and failure together, and sends estimator pulses while waiting and while in error, to catch a wrong priority and pulses that leak into the wrong states.

// File: rtl/spdif_lock_pkg.sv
package spdif_lock_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_SYNC = 3'd2,
    ST_HOLD = 3'd3,
    ST_RECV = 3'd4,
    ST_ERR  = 3'd5
  } lockState_t;

  localparam logic [1:0] MODE_OFF  = 2'd0;
  localparam logic [1:0] MODE_LOCK = 2'd1;
  localparam logic [1:0] MODE_RSV  = 2'd2;
  localparam logic [1:0] MODE_FULL = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;
    logic countFail;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic actReached;
    logic budgetSpent;
  } dpStatus_t;

endpackage

// File: rtl/spdif_lock_dp.sv
module spdif_lock_dp
  import spdif_lock_pkg::*;
#(
  parameter int NUM_LINES   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ACT_EDGES   = 4,
  parameter int CODE_W      = 2,
  parameter int RETRY_STEP  = 2,
  localparam int SEL_W      = $clog2(NUM_LINES),
  localparam int MAX_CODE   = (1 << CODE_W) - 1,
  localparam int FAIL_W     = RETRY_STEP * MAX_CODE + 1,
  localparam int EDGE_W     = $clog2(ACT_EDGES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] serialIn,
  input  logic [SEL_W-1:0]     lineSel,
  input  logic [CODE_W-1:0]    budgetCode,
  input  ctrlStrobe_t          strobe,
  output dpStatus_t            status
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   lastSample;
  logic                   lineEdge;
  logic [EDGE_W-1:0]      edgeCnt;
  logic [FAIL_W-1:0]      failCnt;
  logic [FAIL_W-1:0]      failLimit;

  // synchronizer on the selected line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain  <= '0;
      lastSample <= 1'b0;
    end else begin
      syncChain  <= {syncChain[SYNC_STAGES-2:0], serialIn[lineSel]};
      lastSample <= syncChain[SYNC_STAGES-1];
    end
  end

  assign lineEdge = syncChain[SYNC_STAGES-1] ^ lastSample;

  // activity counter saturates at the threshold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
    end else if (strobe.clrAll) begin
      edgeCnt <= '0;
    end else if (lineEdge && !status.actReached) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  // failed attempt counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failCnt <= '0;
    end else if (strobe.clrAll) begin
      failCnt <= '0;
    end else if (strobe.countFail) begin
      failCnt <= failCnt + 1'b1;
    end
  end

  // retries allowed = 2^(RETRY_STEP*code) - 1
  assign failLimit = FAIL_W'((1 << (RETRY_STEP * int'(budgetCode))) - 1);

  assign status.actReached  = (edgeCnt == EDGE_W'(ACT_EDGES));
  assign status.budgetSpent = (failCnt == failLimit);

endmodule

// File: rtl/spdif_lock_fsm.sv
module spdif_lock_fsm
  import spdif_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  runMode,
  input  logic        waitLine,
  input  logic        estOk,
  input  logic        estFail,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output lockState_t  state,
  output logic        estStart,
  output logic        dataEn
);

  lockState_t nextState;
  logic       startNext;
  logic       modeOn;
  logic       modeFull;

  assign modeOn   = (runMode == MODE_LOCK) || (runMode == MODE_FULL);
  assign modeFull = (runMode == MODE_FULL);

  always_comb begin
    nextState        = state;
    startNext        = 1'b0;
    strobe.countFail = 1'b0;
    strobe.clrAll    = !modeOn;
    if (!modeOn) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (waitLine) begin
            nextState = ST_WAIT;
          end else begin
            nextState = ST_SYNC;
            startNext = 1'b1;
          end
        end
        ST_WAIT: begin
          if (status.actReached) begin
            nextState = ST_SYNC;
            startNext = 1'b1;
          end
        end
        ST_SYNC: begin
          if (estOk) begin
            nextState = modeFull ? ST_RECV : ST_HOLD;
          end else if (estFail) begin
            if (status.budgetSpent) begin
              nextState = ST_ERR;
            end else begin
              strobe.countFail = 1'b1;
              startNext        = 1'b1;
            end
          end
        end
        ST_HOLD: if (modeFull) nextState = ST_RECV;
        ST_RECV: if (!modeFull) nextState = ST_HOLD;
        ST_ERR:  nextState = ST_ERR;
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      estStart <= 1'b0;
    end else begin
      state    <= nextState;
      estStart <= startNext;
    end
  end

  assign dataEn = (state == ST_RECV);

endmodule

// File: rtl/spdif_lock_ctrl.sv
module spdif_lock_ctrl
  import spdif_lock_pkg::*;
#(
  parameter int NUM_LINES   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ACT_EDGES   = 4,
  parameter int CODE_W      = 2,
  parameter int RETRY_STEP  = 2,
  localparam int SEL_W      = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           runMode,
  input  logic [CODE_W-1:0]    budgetCode,
  input  logic                 waitLine,
  input  logic [SEL_W-1:0]     lineSel,
  input  logic [NUM_LINES-1:0] serialIn,
  input  logic                 estOk,
  input  logic                 estFail,
  output logic                 estStart,
  output logic [2:0]           lockState,
  output logic                 dataEn
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;
  lockState_t  fsmState;

  spdif_lock_dp #(
    .NUM_LINES  (NUM_LINES),
    .SYNC_STAGES(SYNC_STAGES),
    .ACT_EDGES  (ACT_EDGES),
    .CODE_W     (CODE_W),
    .RETRY_STEP (RETRY_STEP)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .serialIn  (serialIn),
    .lineSel   (lineSel),
    .budgetCode(budgetCode),
    .strobe    (strobe),
    .status    (status)
  );

  spdif_lock_fsm fsm_i (
    .clk     (clk),
    .rstN    (rstN),
    .runMode (runMode),
    .waitLine(waitLine),
    .estOk   (estOk),
    .estFail (estFail),
    .status  (status),
    .strobe  (strobe),
    .state   (fsmState),
    .estStart(estStart),
    .dataEn  (dataEn)
  );

  assign lockState = fsmState;

endmodule

// File: rtl/spdif_lock_chk.sv
module spdif_lock_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] runMode,
  input logic       estStart,
  input logic [2:0] lockState,
  input logic       dataEn
);

  assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rstN)
    lockState <= 3'd5);

  assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    !runMode[0] |=> (lockState == 3'd0) && !dataEn);

  assert_start_only_locking_R3: assert property (@(posedge clk) disable iff (!rstN)
    estStart |-> lockState == 3'd2);

  assert_entry_has_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lockState == 3'd2 && $past(lockState) != 3'd2) |-> estStart);

  assert_error_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lockState == 3'd5 && runMode[0]) |=> lockState == 3'd5);

  assert_data_needs_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    dataEn |-> $past(runMode) == 2'd3);

endmodule

bind spdif_lock_ctrl spdif_lock_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .runMode  (runMode),
  .estStart (estStart),
  .lockState(lockState),
  .dataEn   (dataEn)
);

// File: tb/spdif_lock_ctrl_tb.sv
module spdif_lock_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] runMode = 2'd0;
  logic [1:0] budgetCode = 2'd0;
  logic       waitLine = 1'b0;
  logic [1:0] lineSel = 2'd0;
  logic [3:0] serialIn = 4'd0;
  logic       estOk = 1'b0;
  logic       estFail = 1'b0;
  logic       estStart;
  logic [2:0] lockState;
  logic       dataEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spdif_lock_ctrl dut_i (
    .clk(clk), .rstN(rstN), .runMode(runMode), .budgetCode(budgetCode),
    .waitLine(waitLine), .lineSel(lineSel), .serialIn(serialIn),
    .estOk(estOk), .estFail(estFail), .estStart(estStart),
    .lockState(lockState), .dataEn(dataEn)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic toggleLine(input int idx);
    serialIn[idx] = ~serialIn[idx];
    tick(4);
  endtask

  task automatic pulseFail();
    estFail = 1'b1; tick(1); estFail = 1'b0;
  endtask

  task automatic pulseOk();
    estOk = 1'b1; tick(1); estOk = 1'b0;
  endtask

  task automatic switchOff();
    runMode = 2'd0; tick(3);
  endtask

  task automatic testReset();
    check("R1 state", lockState, 0);
    check("R1 start", estStart, 0);
    check("R1 dataEn", dataEn, 0);
  endtask

  task automatic testDirectLock();
    switchOff();
    waitLine = 1'b0; budgetCode = 2'd0;
    runMode = 2'd1; tick(1);
    check("R3 state", lockState, 2);
    check("R3 start", estStart, 1);
    tick(1);
    check("R3 one-cycle start", estStart, 0);
    pulseOk();
    check("R9 hold", lockState, 3);
    check("R9 dataEn low", dataEn, 0);
    runMode = 2'd3; tick(1);
    check("R10 hold to recv", lockState, 4);
    check("R10 dataEn", dataEn, 1);
    runMode = 2'd1; tick(1);
    check("R10 recv to hold", lockState, 3);
    runMode = 2'd3; tick(1);
    runMode = 2'd0; tick(1);
    check("R2 off from recv", lockState, 0);
    check("R2 dataEn low", dataEn, 0);
    runMode = 2'd2; tick(3);
    check("R2 reserved stays idle", lockState, 0);
  endtask

  task automatic testFullLock();
    switchOff();
    waitLine = 1'b0;
    runMode = 2'd3; tick(1);
    check("R3 full start", estStart, 1);
    tick(2);
    pulseOk();
    check("R9 recv", lockState, 4);
    check("R9 dataEn", dataEn, 1);
    switchOff();
  endtask

  task automatic testBudget(input int code);
    int allowed = 1 << (2 * code);
    int badRetry = 0;
    switchOff();
    waitLine = 1'b0; budgetCode = 2'(code);
    runMode = 2'd1; tick(1);
    for (int i = 1; i < allowed; i++) begin
      pulseFail();
      if (lockState != 3'd2 || estStart != 1'b1) badRetry++;
    end
    check("R6 retries restart with start", badRetry, 0);
    pulseFail();
    check("R7 error after budget", lockState, 5);
    pulseOk(); tick(4);
    check("R8 error sticky", lockState, 5);
    check("R12 ok ignored in error", dataEn, 0);
    runMode = 2'd0; tick(1);
    check("R8 leave error when off", lockState, 0);
  endtask

  task automatic testActivity();
    switchOff();
    lineSel = 2'd2; waitLine = 1'b1; tick(4);
    runMode = 2'd1; tick(1);
    check("R4 waiting", lockState, 1);
    for (int i = 0; i < 4; i++) toggleLine(0);
    for (int i = 0; i < 4; i++) toggleLine(3);
    check("R5 other lines ignored", lockState, 1);
    pulseFail(); pulseOk();
    check("R12 pulses ignored while waiting", lockState, 1);
    for (int i = 0; i < 3; i++) toggleLine(2);
    check("R4 three changes not enough", lockState, 1);
    serialIn[2] = ~serialIn[2];
    tick(3);
    check("R4 still waiting before latency", lockState, 1);
    tick(1);
    check("R4 locking after fourth change", lockState, 2);
    check("R4 start pulse", estStart, 1);
    switchOff();
  endtask

  task automatic testClear();
    switchOff();
    lineSel = 2'd1; waitLine = 1'b1; tick(4);
    runMode = 2'd3; tick(1);
    for (int i = 0; i < 3; i++) toggleLine(1);
    runMode = 2'd0; tick(2);
    runMode = 2'd3; tick(1);
    toggleLine(1); tick(2);
    check("R2 change count cleared", lockState, 1);
    switchOff();
    waitLine = 1'b0; budgetCode = 2'd1;
    runMode = 2'd1; tick(1);
    pulseFail(); pulseFail();
    runMode = 2'd0; tick(1);
    runMode = 2'd1; tick(1);
    pulseFail(); pulseFail(); pulseFail();
    check("R2 fail count cleared", lockState, 2);
    pulseFail();
    check("R7 budget of four after clear", lockState, 5);
    switchOff();
  endtask

  task automatic testTie();
    switchOff();
    waitLine = 1'b0; budgetCode = 2'd0;
    runMode = 2'd1; tick(1);
    estOk = 1'b1; estFail = 1'b1; tick(1);
    estOk = 1'b0; estFail = 1'b0;
    check("R11 success wins", lockState, 3);
    switchOff();
  endtask

  initial begin
    tick(2);
    testReset();
    rstN = 1'b1;
    tick(2);
    testReset();
    testDirectLock();
    testFullLock();
    for (int c = 0; c < 4; c++) testBudget(c);
    testActivity();
    testClear();
    testTie();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule